// File: doc/BRIEF.md
# Five-State Recovering Sequence Counter

This block is a three-bit counter in which every state bit is clocked by the same falling edge. It does not count in binary. It steps through the fixed loop 7, 6, 5, 4, 1 and then returns to 7. The three codes that are not part of that loop are 0, 2 and 3. Each of them is forced back to 7 on the next falling edge, so the counter recovers from any corrupted value within one clock.

A design parameter picks how the next state is formed. One option uses toggle-type stages, where each stage inverts its bit when its toggle term is 1 and holds it when the term is 0. The other option uses data-type stages that load the next value directly. Both options must give the same successor for every one of the eight codes.

A synchronous reset loads 7.

Top module: `seq_counter7`

## Requirements
- R1: When `rst` is 1 at a falling edge of `clk`, `cnt` becomes 3'b111 on that edge. This holds from any state, including in the middle of the loop.
- R2: `cnt` changes only on falling edges of `clk`. A rising edge leaves `cnt` unchanged.
- R3: With `rst` at 0, the legal codes step on each falling edge as follows: 111 to 110, 110 to 101, 101 to 100, and 100 to 001. The bits of `cnt` are {C, B, A}, with bit 2 as the MSB.
- R4: With `rst` at 0, code 001 steps to 111, so the loop has a period of five falling edges.
- R5: With `rst` at 0, each of the codes 000, 010 and 011 steps to 111 on the next falling edge.
- R6: Parameter `USE_TOGGLE` selects the stage type: 1 selects toggle stages and 0 selects data stages. Both settings give the same successor for all eight codes.
- R7: After recovering from an unused code, the counter continues in the normal loop, going from 111 to 110 on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the falling edge |
| rst | input | 1 | Synchronous reset, active high; loads 3'b111 |
| cnt | output | 3 | Current state {C, B, A} |

## Verification
A walk from reset through ten falling edges shows that the loop order and the wrap from 001 to 111 are correct. This walk also shows that the loop never lands on an unused code.

Forcing each of the eight codes and taking a single step separates the legal successors from the recovery path. The same forced steps, applied to a toggle build and a data build side by side, show whether the two equation sets disagree on any code.

Sampling `cnt` on both sides of each clock edge distinguishes a design that updates on the falling edge from one that updates on the rising edge. A reset applied in the middle of the loop shows that the reset overrides the next-state logic.

// File: rtl/seq_counter7.sv
module seq_counter7 #(
  parameter bit USE_TOGGLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] cnt
);

  logic [2:0] state_q;
  logic [2:0] nxt;
  logic       c, b, a;

  assign c = state_q[2];
  assign b = state_q[1];
  assign a = state_q[0];

  generate
    if (USE_TOGGLE) begin : g_toggle
      logic [2:0] tgl;
      assign tgl[2] = (~a & ~b) | ~c;
      assign tgl[1] = (~b & ~c) | (~a & b & c);
      assign tgl[0] = ~a | c;
      assign nxt = state_q ^ tgl;
    end else begin : g_data
      assign nxt[2] = a | b | ~c;
      assign nxt[1] = (a & b) | ~c;
      assign nxt[0] = ~a | ~c;
    end
  endgenerate

  always_ff @(negedge clk) begin
    if (rst) state_q <= 3'b111;
    else     state_q <= nxt;
  end

  assign cnt = state_q;

endmodule

module seq_counter7_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state,
  input logic [2:0] nxt
);

  p_reset_load_r1: assert property (@(negedge clk)
    rst |=> state == 3'b111);

  p_desc_r3: assert property (@(negedge clk) disable iff (rst)
    (state == 3'b111 || state == 3'b110 || state == 3'b101) |-> nxt == state - 3'd1);

  p_drop_r3: assert property (@(negedge clk) disable iff (rst)
    state == 3'b100 |-> nxt == 3'b001);

  p_wrap_r4: assert property (@(negedge clk) disable iff (rst)
    state == 3'b001 |-> nxt == 3'b111);

  p_recover_r5: assert property (@(negedge clk) disable iff (rst)
    (state == 3'b000 || state == 3'b010 || state == 3'b011) |-> nxt == 3'b111);

endmodule

bind seq_counter7 seq_counter7_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .state(state_q),
  .nxt  (nxt)
);

// File: tb/tb_seq_counter7.sv
module tb_seq_counter7;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b1;
  logic       rst = 1'b1;
  logic [2:0] cnt;
  logic [2:0] cnt_d;
  int checks = 0;
  int errors = 0;

  seq_counter7 #(.USE_TOGGLE(1'b1)) dut      (.clk(clk), .rst(rst), .cnt(cnt));
  seq_counter7 #(.USE_TOGGLE(1'b0)) dut_data (.clk(clk), .rst(rst), .cnt(cnt_d));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] ref_next(input logic [2:0] s);
    case (s)
      3'b111: ref_next = 3'b110;
      3'b110: ref_next = 3'b101;
      3'b101: ref_next = 3'b100;
      3'b100: ref_next = 3'b001;
      default: ref_next = 3'b111;
    endcase
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_both(input string req, input logic [2:0] exp);
    chk({req, " toggle build"}, cnt, exp);
    chk({req, " data build"}, cnt_d, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk_both("R1 reset state", 3'b111);
    rst = 1'b0;
  endtask

  task automatic t_walk;
    logic [2:0] exp = 3'b111;
    for (int i = 0; i < 10; i++) begin
      exp = ref_next(exp);
      @(posedge clk);
      #1;
      chk_both((exp == 3'b111) ? "R4 wrap to 111" : "R3 loop order", exp);
    end
  endtask

  task automatic t_edges;
    logic [2:0] v;
    @(negedge clk);
    #1;
    v = cnt;
    @(posedge clk);
    #1;
    chk("R2 rising edge holds", cnt, v);
    #(CLK_PERIOD/2 - 2);
    chk("R2 stable before falling edge", cnt, v);
    #2;
    chk("R2 falling edge steps", cnt, ref_next(v));
  endtask

  task automatic force_state(input logic [2:0] s);
    @(posedge clk);
    #1;
    force dut.state_q = s;
    force dut_data.state_q = s;
    #1;
    release dut.state_q;
    release dut_data.state_q;
  endtask

  task automatic t_all_codes;
    for (int s = 0; s < 8; s++) begin
      force_state(3'(s));
      @(posedge clk);
      #1;
      if (s == 0 || s == 2 || s == 3)
        chk_both("R5 unused code recovers", 3'b111);
      else
        chk_both("R6 successor per build", ref_next(3'(s)));
      chk("R6 builds agree", cnt, cnt_d);
    end
  endtask

  task automatic t_recover_continue;
    force_state(3'b010);
    @(posedge clk);
    #1;
    chk_both("R5 recovery from 010", 3'b111);
    @(posedge clk);
    #1;
    chk_both("R7 continues after recovery", 3'b110);
    @(posedge clk);
    #1;
    chk_both("R7 continues after recovery", 3'b101);
  endtask

  task automatic t_midrun_reset;
    force_state(3'b100);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk_both("R1 reset overrides 100", 3'b111);
    @(posedge clk);
    #1;
    chk_both("R1 reset holds 111", 3'b111);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk_both("R3 resumes after reset", 3'b110);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_walk();
    t_edges();
    t_all_codes();
    t_recover_continue();
    t_midrun_reset();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule